// File: doc/BRIEF.md
# ATA PIO Device Protocol Engine

This block is the target side of a parallel ATA disk interface. A host reaches it through byte-wide task-file registers in a command block and a control block, plus a 16-bit data register. The block keeps the status and error registers and runs the device protocol state machine. That covers the selected, not-selected and interrupt-pending idle states, PIO data-in and data-out transfers one sector at a time, soft reset, and a small set of non-data commands. It drives an interrupt request line.

Sector data passes through a one-sector word buffer. A storage port moves the buffer to or from backing storage one 16-bit word at a time, using a request/acknowledge handshake. DMA commands are not moved by this block: it presents a ready flag to an external DMA engine and completes the command when that engine reports done. Only LBA addressing is accepted.

Top module: `ata_pio_dev`

## Requirements
- R1: After reset, status reads 0x40 (only device-ready set), error reads 0x01, and the interrupt line is low.
- R2: The device-select bit is bit 4 of the drive/head register (command block offset 6). With a device ID of 0, writing 1 there deselects the device, and a command written while deselected has no effect. Writing 0 there selects the device again.
- R3: From the clock edge that captures a command-register write (command block offset 7), status reads 0xC0: busy and ready set, data-request, fault, seek and error clear.
- R4: A non-data command (for example 0xE7) completes with status 0x40. When interrupts are enabled, it raises the interrupt line. A status read (command block offset 7) drops the line. An alternate-status read (control block offset 6) leaves it unchanged.
- R5: While the interrupt-disable bit (bit 1 of the control register, control block offset 6) is set, no interrupt is raised.
- R6: PIO read (0x20) loads each sector from storage at consecutive LBAs. Each sector then shows status 0x48 and posts an interrupt, and a status read clears it. Successive data-register reads return the sector's words in order. After the final word, status is 0x40 and no interrupt is raised.
- R7: A sector count of 0 transfers 256 sectors.
- R8: PIO write (0x30) raises no interrupt for the first sector. After the last word of each sector, status is 0xD0 (busy, ready, seek) and the sector is written to storage. Each later sector posts an interrupt with status 0x58. Completion gives status 0x50 with an interrupt.
- R9: Setting bit 2 of the control register forces status 0x80 and drops the interrupt. Clearing that bit returns the reset values: status 0x40, error 0x01, task-file registers 0.
- R10: Read-max-address (0xF8) puts capacity minus one into the sector number register (bits 7:0), the cylinder-low register (bits 15:8) and the cylinder-high register (bits 23:16). Bits 27:24 go into the low nibble of the drive/head register.
- R11: A data command without the LBA bit (bit 6 of the drive/head register), or an unknown opcode, completes with status 0x41 and error 0x04. It raises an interrupt unless interrupts are disabled.
- R12: DMA commands (0xC8, 0xCA) assert dma_ready with status 0x48. A dma_done pulse completes the command with status 0x50 and an interrupt.
- R13: A storage request keeps its LBA and word index stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_cmd_blk | input | 1 | 1 selects the command block, 0 the control block |
| reg_addr | input | 3 | Register offset within the block |
| reg_rd | input | 1 | One-cycle read strobe (triggers read side effects) |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_wdata | input | 16 | Write data (byte registers use bits 7:0) |
| reg_rdata | output | 16 | Read data for the addressed register |
| intrq | output | 1 | Interrupt request |
| sto_req | output | 1 | Storage word request |
| sto_we | output | 1 | 1 = write to storage, 0 = read |
| sto_lba | output | 28 | Sector address of the request |
| sto_widx | output | AW | Word index within the sector |
| sto_wdata | output | 16 | Word written to storage |
| sto_rdata | input | 16 | Word returned by storage |
| sto_ack | input | 1 | Storage accepts or returns the current word |
| dma_ready | output | 1 | DMA command waiting for the external engine |
| dma_done | input | 1 | External engine finished the transfer |

## Verification
On every cycle, the assertions check four things: busy and data-request are never set together, an interrupt never rises while interrupts are disabled, a status read always clears a pending interrupt, and a storage request stays stable until acknowledged. They also check that dma_ready appears only together with data-request. The order of events within a command can only be shown by the directed scenarios. These include the interrupt being skipped for the first write sector, the 256-sector meaning of a zero count, the data words and LBAs reaching storage, the read-max-address split, and the return to reset values after soft reset.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    // status register masks
    localparam logic [7:0] M_BSY  = 8'h80;
    localparam logic [7:0] M_DRDY = 8'h40;
    localparam logic [7:0] M_SEEK = 8'h10;
    localparam logic [7:0] M_DRQ  = 8'h08;
    localparam logic [7:0] M_ERR  = 8'h01;

    localparam logic [7:0] ERR_DIAG_OK = 8'h01;
    localparam logic [7:0] ERR_ABORT   = 8'h04;

    localparam int DRV_LBA  = 6;
    localparam int DRV_DEV  = 4;
    localparam int CTL_NIEN = 1;
    localparam int CTL_SRST = 2;

    // command block offsets; the control register shares offset 6
    localparam logic [2:0] A_DATA  = 3'd0;
    localparam logic [2:0] A_ERR   = 3'd1;
    localparam logic [2:0] A_COUNT = 3'd2;
    localparam logic [2:0] A_LBA0  = 3'd3;
    localparam logic [2:0] A_LBA1  = 3'd4;
    localparam logic [2:0] A_LBA2  = 3'd5;
    localparam logic [2:0] A_DRIVE = 3'd6;
    localparam logic [2:0] A_CMD   = 3'd7;
    localparam logic [2:0] A_CTRL  = 3'd6;

    typedef enum logic [2:0] {
        K_NODATA, K_MAXADDR, K_PIO_IN, K_PIO_OUT, K_DMA, K_BAD
    } cmd_kind_e;

    typedef enum logic [3:0] {
        S_IDLE_SEL, S_IDLE_NSEL, S_IDLE_INT, S_SRST, S_EXEC,
        S_LOAD, S_IN_WAIT, S_IN_XFER, S_OUT_WAIT, S_OUT_XFER,
        S_STORE, S_DMA
    } dev_state_e;

    typedef struct packed {
        logic [7:0] count;
        logic [7:0] lba0;
        logic [7:0] lba1;
        logic [7:0] lba2;
        logic [7:0] drive;
    } taskfile_t;

    function automatic cmd_kind_e classify(input logic [7:0] op, input logic lba_mode);
        case (op)
            8'h20, 8'h21, 8'hC4: return lba_mode ? K_PIO_IN : K_BAD;
            8'h30, 8'h31, 8'hC5: return lba_mode ? K_PIO_OUT : K_BAD;
            8'hC8, 8'hCA:        return lba_mode ? K_DMA : K_BAD;
            8'hF8:               return K_MAXADDR;
            8'h10, 8'h40, 8'h70, 8'h91, 8'hC6, 8'hE0, 8'hE7, 8'hEF:
                                 return K_NODATA;
            default:             return K_BAD;
        endcase
    endfunction

    function automatic logic [8:0] sectors_of(input logic [7:0] cnt);
        return (cnt == 8'd0) ? 9'd256 : {1'b0, cnt};
    endfunction

endpackage

// File: rtl/ata_sector_buf.sv
module ata_sector_buf #(
    parameter int WORDS = 256,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [15:0]   rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [15:0]   rdata_b
);
    logic [15:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/ata_sto_seq.sv
module ata_sto_seq #(
    parameter int WORDS = 256,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          start,
    input  logic          we_i,
    input  logic [27:0]   lba_i,
    output logic          sto_req,
    output logic          sto_we,
    output logic [27:0]   sto_lba,
    output logic [AW-1:0] sto_widx,
    input  logic          sto_ack,
    output logic          done,
    output logic          fill_we
);
    localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

    logic          busy;
    logic [AW-1:0] idx;
    logic          we_r;
    logic [27:0]   lba_r;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy  <= 1'b0;
            idx   <= '0;
            we_r  <= 1'b0;
            lba_r <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            idx   <= '0;
            we_r  <= we_i;
            lba_r <= lba_i;
        end else if (busy && sto_ack) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
            if (idx == LAST) busy <= 1'b0;
        end
    end

    assign sto_req  = busy;
    assign sto_we   = we_r;
    assign sto_lba  = lba_r;
    assign sto_widx = idx;
    assign done     = busy && sto_ack && (idx == LAST);
    assign fill_we  = busy && sto_ack && !we_r;

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst || abort)
        (sto_req && !sto_ack) |=> (sto_req && $stable(sto_lba) && $stable(sto_widx)));
endmodule

// File: rtl/ata_pio_dev.sv
module ata_pio_dev
    import ata_pio_pkg::*;
#(
    parameter int          DEV_ID       = 0,
    parameter int          SECTOR_WORDS = 256,
    parameter logic [27:0] CAPACITY     = 28'h0100000,
    localparam int         AW           = $clog2(SECTOR_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_cmd_blk,
    input  logic [2:0]    reg_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    output logic          intrq,
    output logic          sto_req,
    output logic          sto_we,
    output logic [27:0]   sto_lba,
    output logic [AW-1:0] sto_widx,
    output logic [15:0]   sto_wdata,
    input  logic [15:0]   sto_rdata,
    input  logic          sto_ack,
    output logic          dma_ready,
    input  logic          dma_done
);
    localparam logic [AW-1:0] LAST_W   = AW'(SECTOR_WORDS - 1);
    localparam logic [27:0]   MAX_LBA  = CAPACITY - 28'd1;
    localparam logic          SELF     = (DEV_ID != 0);
    localparam dev_state_e    HOME     = (DEV_ID == 0) ? S_IDLE_SEL : S_IDLE_NSEL;

    dev_state_e  state;
    cmd_kind_e   kind;
    taskfile_t   tf;
    logic [7:0]  status, err_r;
    logic        nien, intr_pend;
    logic [8:0]  left;
    logic [AW-1:0] widx;
    logic [27:0] cur_lba;

    // host strobes
    logic wr_cb, rd_cb, wr_drive, wr_cmd, wr_data, rd_data, rd_stat, wr_ctrl;
    logic ctl_srst, srst_release, sel_w;
    assign wr_cb    = reg_wr && reg_cmd_blk;
    assign rd_cb    = reg_rd && reg_cmd_blk;
    assign wr_drive = wr_cb && (reg_addr == A_DRIVE);
    assign wr_cmd   = wr_cb && (reg_addr == A_CMD);
    assign wr_data  = wr_cb && (reg_addr == A_DATA);
    assign rd_data  = rd_cb && (reg_addr == A_DATA);
    assign rd_stat  = rd_cb && (reg_addr == A_CMD);
    assign wr_ctrl  = reg_wr && !reg_cmd_blk && (reg_addr == A_CTRL);
    assign ctl_srst = wr_ctrl && reg_wdata[CTL_SRST];
    assign srst_release = wr_ctrl && !reg_wdata[CTL_SRST] && (state == S_SRST);
    assign sel_w    = (reg_wdata[DRV_DEV] == SELF);

    // storage sequencer and sector buffer
    logic seq_start, seq_we, seq_done, fill_we, host_wr, buf_we;
    logic [27:0] seq_lba;
    logic [AW-1:0] buf_waddr;
    logic [15:0] buf_wdata, host_word;

    assign seq_start = (state == S_EXEC && kind == K_PIO_IN)
                    || (state == S_IN_XFER && rd_data && widx == LAST_W && left != 9'd1)
                    || (state == S_OUT_XFER && wr_data && widx == LAST_W);
    assign seq_we    = (state == S_OUT_XFER);
    assign seq_lba   = (state == S_IN_XFER) ? cur_lba + 28'd1 : cur_lba;

    ata_sto_seq #(.WORDS(SECTOR_WORDS)) u_seq (
        .clk(clk), .rst(rst), .abort(ctl_srst || state == S_SRST),
        .start(seq_start), .we_i(seq_we), .lba_i(seq_lba),
        .sto_req(sto_req), .sto_we(sto_we), .sto_lba(sto_lba),
        .sto_widx(sto_widx), .sto_ack(sto_ack),
        .done(seq_done), .fill_we(fill_we)
    );

    assign host_wr   = (state == S_OUT_XFER) && wr_data;
    assign buf_we    = host_wr || fill_we;
    assign buf_waddr = host_wr ? widx : sto_widx;
    assign buf_wdata = host_wr ? reg_wdata : sto_rdata;

    ata_sector_buf #(.WORDS(SECTOR_WORDS)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
        .raddr_a(widx), .rdata_a(host_word),
        .raddr_b(sto_widx), .rdata_b(sto_wdata)
    );

    // command completion decision
    logic fin, fin_err, fin_seek;
    always_comb begin
        fin = 1'b0;
        fin_err = 1'b0;
        fin_seek = 1'b0;
        case (state)
            S_EXEC: begin
                fin     = (kind == K_NODATA) || (kind == K_MAXADDR) || (kind == K_BAD);
                fin_err = (kind == K_BAD);
            end
            S_STORE: begin
                fin      = seq_done && (left == 9'd1);
                fin_seek = 1'b1;
            end
            S_DMA: begin
                fin      = dma_done;
                fin_seek = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || srst_release) begin
            state     <= HOME;
            kind      <= K_NODATA;
            tf        <= '0;
            status    <= M_DRDY;
            err_r     <= ERR_DIAG_OK;
            nien      <= !rst && reg_wdata[CTL_NIEN];
            intr_pend <= 1'b0;
            left      <= '0;
            widx      <= '0;
            cur_lba   <= '0;
        end else if (ctl_srst) begin
            state     <= S_SRST;
            status    <= M_BSY;
            intr_pend <= 1'b0;
            nien      <= reg_wdata[CTL_NIEN];
        end else begin
            if (wr_ctrl) nien <= reg_wdata[CTL_NIEN];
            if (wr_cb) begin
                case (reg_addr)
                    A_COUNT: tf.count <= reg_wdata[7:0];
                    A_LBA0:  tf.lba0  <= reg_wdata[7:0];
                    A_LBA1:  tf.lba1  <= reg_wdata[7:0];
                    A_LBA2:  tf.lba2  <= reg_wdata[7:0];
                    A_DRIVE: tf.drive <= reg_wdata[7:0];
                    default: ;
                endcase
            end
            if (fin) begin
                status <= M_DRDY | (fin_seek ? M_SEEK : 8'h00) | (fin_err ? M_ERR : 8'h00);
                if (fin_err) err_r <= ERR_ABORT;
                if (state == S_EXEC && kind == K_MAXADDR) begin
                    tf.lba0  <= MAX_LBA[7:0];
                    tf.lba1  <= MAX_LBA[15:8];
                    tf.lba2  <= MAX_LBA[23:16];
                    tf.drive <= {tf.drive[7:4], MAX_LBA[27:24]};
                end
                if (!nien) begin
                    state     <= S_IDLE_INT;
                    intr_pend <= 1'b1;
                end else begin
                    state <= S_IDLE_SEL;
                end
            end else begin
                case (state)
                    S_IDLE_SEL: begin
                        if (wr_drive && !sel_w) state <= S_IDLE_NSEL;
                        else if (wr_cmd) begin
                            status  <= M_BSY | M_DRDY;
                            err_r   <= 8'h00;
                            kind    <= classify(reg_wdata[7:0], tf.drive[DRV_LBA]);
                            left    <= sectors_of(tf.count);
                            cur_lba <= {tf.drive[3:0], tf.lba2, tf.lba1, tf.lba0};
                            state   <= S_EXEC;
                        end
                    end
                    S_IDLE_NSEL: if (wr_drive && sel_w) state <= S_IDLE_SEL;
                    S_IDLE_INT: begin
                        if (wr_drive && !sel_w) begin
                            state     <= S_IDLE_NSEL;
                            intr_pend <= 1'b0;
                        end else if (rd_stat || nien) begin
                            state     <= S_IDLE_SEL;
                            intr_pend <= 1'b0;
                        end else if (wr_cmd) begin
                            intr_pend <= 1'b0;
                            status    <= M_BSY | M_DRDY;
                            err_r     <= 8'h00;
                            kind      <= classify(reg_wdata[7:0], tf.drive[DRV_LBA]);
                            left      <= sectors_of(tf.count);
                            cur_lba   <= {tf.drive[3:0], tf.lba2, tf.lba1, tf.lba0};
                            state     <= S_EXEC;
                        end
                    end
                    S_EXEC: begin
                        widx <= '0;
                        case (kind)
                            K_PIO_IN:  state <= S_LOAD;
                            K_PIO_OUT: begin
                                status <= M_DRDY | M_DRQ;
                                state  <= S_OUT_XFER;
                            end
                            K_DMA: begin
                                status <= M_DRDY | M_DRQ;
                                state  <= S_DMA;
                            end
                            default: ;
                        endcase
                    end
                    S_LOAD: if (seq_done) begin
                        status <= M_DRDY | M_DRQ;
                        widx   <= '0;
                        if (!nien) begin
                            state     <= S_IN_WAIT;
                            intr_pend <= 1'b1;
                        end else begin
                            state <= S_IN_XFER;
                        end
                    end
                    S_IN_WAIT: if (rd_stat) begin
                        state     <= S_IN_XFER;
                        intr_pend <= 1'b0;
                    end
                    S_IN_XFER: if (rd_data) begin
                        if (widx == LAST_W) begin
                            widx <= '0;
                            if (left == 9'd1) begin
                                status <= M_DRDY;
                                state  <= S_IDLE_SEL;
                            end else begin
                                status  <= M_BSY | M_DRDY;
                                left    <= left - 9'd1;
                                cur_lba <= cur_lba + 28'd1;
                                state   <= S_LOAD;
                            end
                        end else begin
                            widx <= widx + 1'b1;
                        end
                    end
                    S_OUT_WAIT: if (rd_stat) begin
                        state     <= S_OUT_XFER;
                        intr_pend <= 1'b0;
                    end
                    S_OUT_XFER: if (wr_data) begin
                        if (widx == LAST_W) begin
                            widx   <= '0;
                            status <= M_BSY | M_DRDY | M_SEEK;
                            state  <= S_STORE;
                        end else begin
                            widx <= widx + 1'b1;
                        end
                    end
                    S_STORE: if (seq_done) begin
                        left    <= left - 9'd1;
                        cur_lba <= cur_lba + 28'd1;
                        status  <= M_DRDY | M_SEEK | M_DRQ;
                        if (nien) state <= S_OUT_XFER;
                        else begin
                            state     <= S_OUT_WAIT;
                            intr_pend <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // register read multiplexer
    always_comb begin
        reg_rdata = 16'h0000;
        if (reg_cmd_blk) begin
            case (reg_addr)
                A_DATA:  reg_rdata = host_word;
                A_ERR:   reg_rdata = {8'h00, err_r};
                A_COUNT: reg_rdata = {8'h00, tf.count};
                A_LBA0:  reg_rdata = {8'h00, tf.lba0};
                A_LBA1:  reg_rdata = {8'h00, tf.lba1};
                A_LBA2:  reg_rdata = {8'h00, tf.lba2};
                A_DRIVE: reg_rdata = {8'h00, tf.drive};
                default: reg_rdata = {8'h00, status};
            endcase
        end else if (reg_addr == A_CTRL) begin
            reg_rdata = {8'h00, status};
        end
    end

    assign intrq     = intr_pend;
    assign dma_ready = (state == S_DMA);

    assert_bsy_drq_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(status[7] && status[3]));
    assert_nien_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(intrq) |-> !$past(nien));
    assert_stat_ack_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && intrq && !reg_wr) |=> !intrq);
    assert_dma_handshake_R12: assert property (@(posedge clk) disable iff (rst)
        dma_ready |-> (status[3] && !status[7]));
endmodule

// File: tb/ata_pio_dev_tb.sv
`timescale 1ns/1ps
module ata_pio_dev_tb;
    localparam int WORDS = 2;
    localparam logic [27:0] CAP = 28'h9ABCDEF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_cmd_blk = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0, reg_rdata;
    logic intrq, sto_req, sto_we, sto_ack = 1'b0, dma_ready, dma_done = 1'b0;
    logic [27:0] sto_lba;
    logic [0:0] sto_widx;
    logic [15:0] sto_wdata, sto_rdata = 16'h0;
    logic [15:0] wmem [8];

    int nchk = 0, nfail = 0;

    always #2 clk = ~clk;

    ata_pio_dev #(.DEV_ID(0), .SECTOR_WORDS(WORDS), .CAPACITY(CAP)) u_dut (
        .clk(clk), .rst(rst), .reg_cmd_blk(reg_cmd_blk), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .intrq(intrq), .sto_req(sto_req), .sto_we(sto_we), .sto_lba(sto_lba),
        .sto_widx(sto_widx), .sto_wdata(sto_wdata), .sto_rdata(sto_rdata),
        .sto_ack(sto_ack), .dma_ready(dma_ready), .dma_done(dma_done)
    );

    function automatic logic [15:0] pat(input logic [27:0] l, input int i);
        return {l[7:0], 8'(i)} ^ 16'h3C00;
    endfunction

    // storage model: acknowledges every other cycle
    always @(posedge clk) begin
        sto_ack   <= sto_req && !sto_ack;
        sto_rdata <= pat(sto_lba, int'(sto_widx));
        if (sto_req && sto_ack && sto_we) wmem[{sto_lba[1:0], sto_widx}] <= sto_wdata;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic cb, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_cmd_blk = cb; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic cb, input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_cmd_blk = cb; reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek_alt(output logic [15:0] d);
        reg_cmd_blk = 1'b0; reg_addr = 3'd6;
        #1 d = reg_rdata;
    endtask

    task automatic wait_ready(output logic [15:0] s);
        s = 16'h80;
        for (int i = 0; i < 100 && s[7]; i++) bus_rd(1'b0, 3'd6, s);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        bus_rd(1'b0, 3'd6, d); chk("R1 status", d, 16'h40);
        bus_rd(1'b1, 3'd1, d); chk("R1 error", d, 16'h01);
        chk("R1 intrq", {15'd0, intrq}, 16'd0);
    endtask

    task automatic t_nondata();
        logic [15:0] d;
        bus_wr(1'b1, 3'd6, 16'h40);
        bus_wr(1'b1, 3'd7, 16'hE7);
        peek_alt(d); chk("R3 busy on accept", d, 16'hC0);
        wait_ready(d); chk("R4 done status", d, 16'h40);
        chk("R4 intr raised", {15'd0, intrq}, 16'd1);
        bus_rd(1'b0, 3'd6, d);
        chk("R4 altstatus keeps intr", {15'd0, intrq}, 16'd1);
        bus_rd(1'b1, 3'd7, d);
        chk("R4 status read clears intr", {15'd0, intrq}, 16'd0);
    endtask

    task automatic t_nien();
        logic [15:0] d;
        bus_wr(1'b0, 3'd6, 16'h02);
        bus_wr(1'b1, 3'd7, 16'hE7);
        wait_ready(d); chk("R5 status", d, 16'h40);
        repeat (3) @(negedge clk);
        chk("R5 no intr", {15'd0, intrq}, 16'd0);
        bus_wr(1'b0, 3'd6, 16'h00);
    endtask

    task automatic t_select();
        logic [15:0] d;
        bus_wr(1'b1, 3'd6, 16'h50);
        bus_wr(1'b1, 3'd7, 16'hE7);
        peek_alt(d); chk("R2 deselected ignores cmd", d, 16'h40);
        repeat (3) @(negedge clk);
        chk("R2 no intr when deselected", {15'd0, intrq}, 16'd0);
        bus_wr(1'b1, 3'd6, 16'h40);
        bus_wr(1'b1, 3'd7, 16'hE7);
        peek_alt(d); chk("R2 reselected accepts cmd", d, 16'hC0);
        wait_ready(d);
        bus_rd(1'b1, 3'd7, d);
    endtask

    task automatic t_pio_read();
        logic [15:0] d;
        bus_wr(1'b1, 3'd2, 16'h02);
        bus_wr(1'b1, 3'd3, 16'h10);
        bus_wr(1'b1, 3'd4, 16'h00);
        bus_wr(1'b1, 3'd5, 16'h00);
        bus_wr(1'b1, 3'd6, 16'h40);
        bus_wr(1'b1, 3'd7, 16'h20);
        for (int s = 0; s < 2; s++) begin
            wait_ready(d); chk("R6 block status", d, 16'h48);
            chk("R6 block intr", {15'd0, intrq}, 16'd1);
            bus_rd(1'b1, 3'd7, d);
            chk("R6 intr cleared", {15'd0, intrq}, 16'd0);
            for (int w = 0; w < WORDS; w++) begin
                bus_rd(1'b1, 3'd0, d);
                chk("R6 data word", d, pat(28'h10 + 28'(s), w));
            end
        end
        wait_ready(d); chk("R6 end status", d, 16'h40);
        chk("R6 no end intr", {15'd0, intrq}, 16'd0);
    endtask

    task automatic t_count_zero();
        logic [15:0] d;
        int n = 0, bad = 0;
        bus_wr(1'b0, 3'd6, 16'h02);
        bus_wr(1'b1, 3'd2, 16'h00);
        bus_wr(1'b1, 3'd3, 16'h00);
        bus_wr(1'b1, 3'd7, 16'h20);
        for (int i = 0; i < 600; i++) begin
            wait_ready(d);
            if (!d[3]) break;
            bus_rd(1'b1, 3'd0, d);
            if (d !== pat(28'(n / WORDS), n % WORDS)) bad++;
            n++;
        end
        chk("R7 words for count 0", 16'(n), 16'(256 * WORDS));
        chk("R7 data mismatches", 16'(bad), 16'd0);
        bus_wr(1'b0, 3'd6, 16'h00);
    endtask

    task automatic t_pio_write();
        logic [15:0] d;
        bus_wr(1'b1, 3'd2, 16'h02);
        bus_wr(1'b1, 3'd3, 16'h04);
        bus_wr(1'b1, 3'd7, 16'h30);
        wait_ready(d); chk("R8 first block status", d, 16'h48);
        chk("R8 first block no intr", {15'd0, intrq}, 16'd0);
        bus_wr(1'b1, 3'd0, 16'h1111);
        bus_wr(1'b1, 3'd0, 16'h2222);
        peek_alt(d); chk("R8 sector full status", d, 16'hD0);
        wait_ready(d); chk("R8 second block status", d, 16'h58);
        chk("R8 second block intr", {15'd0, intrq}, 16'd1);
        bus_rd(1'b1, 3'd7, d);
        bus_wr(1'b1, 3'd0, 16'h3333);
        bus_wr(1'b1, 3'd0, 16'h4444);
        wait_ready(d); chk("R8 final status", d, 16'h50);
        chk("R8 final intr", {15'd0, intrq}, 16'd1);
        bus_rd(1'b1, 3'd7, d);
        chk("R8 stored w0", wmem[0], 16'h1111);
        chk("R8 stored w1", wmem[1], 16'h2222);
        chk("R8 stored w2", wmem[2], 16'h3333);
        chk("R8 stored w3", wmem[3], 16'h4444);
    endtask

    task automatic t_reject();
        logic [15:0] d;
        bus_wr(1'b1, 3'd6, 16'h00);
        bus_wr(1'b1, 3'd7, 16'h20);
        wait_ready(d); chk("R11 CHS status", d, 16'h41);
        bus_rd(1'b1, 3'd1, d); chk("R11 CHS error", d, 16'h04);
        chk("R11 CHS intr", {15'd0, intrq}, 16'd1);
        bus_rd(1'b1, 3'd7, d);
        bus_wr(1'b0, 3'd6, 16'h02);
        bus_wr(1'b1, 3'd6, 16'h40);
        bus_wr(1'b1, 3'd7, 16'hAB);
        wait_ready(d); chk("R11 bad opcode status", d, 16'h41);
        bus_rd(1'b1, 3'd1, d); chk("R11 bad opcode error", d, 16'h04);
        chk("R11 no intr under nIEN", {15'd0, intrq}, 16'd0);
        bus_wr(1'b0, 3'd6, 16'h00);
    endtask

    task automatic t_maxaddr();
        logic [15:0] d;
        bus_wr(1'b1, 3'd6, 16'hE0);
        bus_wr(1'b1, 3'd7, 16'hF8);
        wait_ready(d);
        bus_rd(1'b1, 3'd3, d); chk("R10 bits 7:0", d, 16'hEE);
        bus_rd(1'b1, 3'd4, d); chk("R10 bits 15:8", d, 16'hCD);
        bus_rd(1'b1, 3'd5, d); chk("R10 bits 23:16", d, 16'hAB);
        bus_rd(1'b1, 3'd6, d); chk("R10 bits 27:24", d, 16'hE9);
        bus_rd(1'b1, 3'd7, d);
    endtask

    task automatic t_dma();
        logic [15:0] d;
        bus_wr(1'b1, 3'd6, 16'h40);
        bus_wr(1'b1, 3'd2, 16'h01);
        bus_wr(1'b1, 3'd7, 16'hC8);
        wait_ready(d); chk("R12 dma status", d, 16'h48);
        chk("R12 dma_ready", {15'd0, dma_ready}, 16'd1);
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        peek_alt(d); chk("R12 done status", d, 16'h50);
        chk("R12 done intr", {15'd0, intrq}, 16'd1);
        chk("R12 ready dropped", {15'd0, dma_ready}, 16'd0);
        bus_rd(1'b1, 3'd7, d);
    endtask

    task automatic t_srst();
        logic [15:0] d;
        bus_wr(1'b1, 3'd2, 16'h03);
        bus_wr(1'b1, 3'd7, 16'h30);
        wait_ready(d);
        bus_wr(1'b0, 3'd6, 16'h04);
        peek_alt(d); chk("R9 srst status", d, 16'h80);
        chk("R9 srst intr", {15'd0, intrq}, 16'd0);
        bus_wr(1'b0, 3'd6, 16'h00);
        peek_alt(d); chk("R9 release status", d, 16'h40);
        bus_rd(1'b1, 3'd1, d); chk("R9 release error", d, 16'h01);
        bus_rd(1'b1, 3'd2, d); chk("R9 taskfile cleared", d, 16'h00);
        bus_wr(1'b1, 3'd7, 16'hE7);
        peek_alt(d); chk("R9 selected after release", d, 16'hC0);
        wait_ready(d);
        bus_rd(1'b1, 3'd7, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_nondata();
        t_nien();
        t_select();
        t_pio_read();
        t_count_zero();
        t_pio_write();
        t_reject();
        t_maxaddr();
        t_dma();
        t_srst();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule